// File: doc/BRIEF.md
# Serial Flash Continuous-Read Command Front End

This block sits at the slave side of a serial flash interface and follows the command traffic on chip select, serial clock and four data lines. With continuous mode clear, it takes an 8-bit instruction on IO0. A dual-line fast read (BBh) or a quad-line fast read (EBh) goes on to gather a 24-bit address and an 8-bit mode byte over two or four lines. Any other instruction is reported as a decoded opcode. When a read completes, the block issues a one-cycle read-start strobe that carries the address and the line width.

A mode byte whose upper nibble is hex A arms a continuous-read state that lasts across transactions. While it is armed, every transaction begins directly with the address phase. The lane width is the one of the read that armed it. Standard single-line instructions are not decoded in this state. The device has no dedicated pin to leave this state. A short transaction of exactly eight clocks with IO0 held high disarms it and restores normal instruction decoding.

All bus inputs are taken as already synchronous to `clk`. SCLK is oversampled: a rising SCLK edge is recognised one `clk` after it is registered, so SCLK must stay high and low for at least two `clk` periods each. `rst` is the power-on reset of the logic. It is the only way, apart from the bus protocol, to clear the continuous-mode flag.

Top module: `cread_tracker`

## Requirements
- R1: After `rst`, `cont_mode`, `rd_start` and `cmd_valid` are 0, and the first transaction is decoded as an instruction.
- R2: With continuous mode clear, the first 8 IO0 bits (MSB first, sampled on rising SCLK) form the opcode. An opcode other than BBh or EBh produces one `cmd_valid` pulse with that value on `cmd_opcode`, and no `rd_start`.
- R3: After BBh, the address is taken as 12 clocks of 2 bits and the mode byte as 4 clocks of 2 bits. Each pair is {IO1, IO0}, IO1 more significant, MSB first. One `rd_start` pulse follows, with `rd_addr` equal to the address and `rd_quad`=0.
- R4: After EBh, the address is taken as 6 clocks of 4 bits and the mode byte as 2 clocks of 4 bits. Each nibble is {IO3..IO0}, MSB first. Four dummy clocks follow, then one `rd_start` pulse with `rd_quad`=1.
- R5: When a read's strobe is issued, `cont_mode` becomes 1 if the mode byte's upper nibble is Ah, and 0 for any other upper nibble.
- R6: With `cont_mode`=1, the next transaction starts at the address phase with no opcode. It uses the lane width of the read that set the flag and ends in a strobe as in R3 or R4.
- R7: With `cont_mode`=1, no `cmd_valid` is produced, whatever bits arrive on IO0 (for example 9Fh or 0Bh).
- R8: With `cont_mode`=1, a transaction of exactly 8 clocks with IO0 high on every clock clears `cont_mode` when CS_n rises. IO1..IO3 do not matter. No strobe is produced, and the following transaction is decoded as an instruction.
- R9: With `cont_mode`=1, a transaction of 7 or 9 all-ones clocks, or of 8 clocks with any IO0 low, leaves `cont_mode` set and produces no strobe.
- R10: CS_n rising during the address, mode or dummy phase gives no strobe and leaves `cont_mode` unchanged.
- R11: `cont_mode` changes only when a read strobe is issued or when a transaction ends as in R8.
- R12: `rd_start` and `cmd_valid` each last one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high power-on reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| io | input | 4 | Data lines IO3..IO0 |
| rd_start | output | 1 | One-cycle strobe: a dual/quad read may begin |
| rd_addr | output | 24 | Address captured for the strobed read |
| rd_quad | output | 1 | 1 for a four-line read, 0 for two-line |
| cmd_valid | output | 1 | One-cycle strobe for a decoded standard instruction |
| cmd_opcode | output | 8 | Instruction byte qualified by `cmd_valid` |
| cont_mode | output | 1 | Current continuous-read flag |

## Verification
In quad continuous mode, the eighth clock both completes the mode byte and closes the window in which an all-ones IO0 pattern counts as the disarm sequence. So a read capture and a mode reset claim the same bit stream. The bench drives identical all-ones data in both cases. In one it raises CS_n right after clock eight and expects the flag cleared with no strobe. In the other it lets the four dummy clocks run and expects a strobe to address FFFFFFh with the flag cleared by the non-A mode nibble. Transactions cut short at every clock count, and the reset window shifted to 7 and 9 clocks or broken by a single zero at each position, show which of the two outcomes wins.

// File: rtl/cread_pkg.sv
package cread_pkg;

    // Default geometry of the transaction
    localparam int ADDR_W_DEF     = 24;
    localparam int QUAD_DUMMY_DEF = 4;
    localparam int OPC_W          = 8;
    localparam int RESET_CLKS     = 8;

    localparam logic [OPC_W-1:0] OPC_DUAL_IO = 8'hBB;
    localparam logic [OPC_W-1:0] OPC_QUAD_IO = 8'hEB;
    localparam logic [3:0]       CONT_KEY    = 4'hA;

    // Number of data lines used per SCLK edge
    typedef enum logic [1:0] {
        LN_X1 = 2'd0,
        LN_X2 = 2'd1,
        LN_X4 = 2'd2
    } lane_e;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_DECODE,
        ST_ADDR,
        ST_MODE,
        ST_DUMMY,
        ST_COMMIT,
        ST_HOLD
    } state_e;

    // One registered view of the bus per system clock
    typedef struct packed {
        logic       cs_hi;
        logic       rise;
        logic [3:0] io;
    } bus_evt_t;

    function automatic logic is_cont_key(input logic [OPC_W-1:0] mode);
        return mode[OPC_W-1 -: 4] == CONT_KEY;
    endfunction

endpackage

// File: rtl/cread_sampler.sv
module cread_sampler
    import cread_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic [3:0] io,
    output bus_evt_t   evt
);

    logic       cs_q;
    logic       sclk_q;
    logic       sclk_qq;
    logic [3:0] io_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q    <= 1'b1;
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
            io_q    <= '0;
        end else begin
            cs_q    <= cs_n;
            sclk_q  <= sclk;
            sclk_qq <= sclk_q;
            io_q    <= io;
        end
    end

    always_comb begin
        evt.cs_hi = cs_q;
        evt.rise  = sclk_q & ~sclk_qq & ~cs_q;
        evt.io    = io_q;
    end

endmodule

// File: rtl/cread_lane_shift.sv
module cread_lane_shift
    import cread_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  lane_e        lane,
    input  logic [3:0]   io,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            unique case (lane)
                LN_X1:   q <= {q[W-2:0], io[0]};
                LN_X2:   q <= {q[W-3:0], io[1:0]};
                LN_X4:   q <= {q[W-5:0], io};
                default: q <= q;
            endcase
        end
    end

    AST_LANE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        en |-> (lane == LN_X1 || lane == LN_X2 || lane == LN_X4)); // R3

endmodule

// File: rtl/cread_sequencer.sv
module cread_sequencer
    import cread_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int QUAD_DUMMY = QUAD_DUMMY_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_hi,
    input  logic              rise,
    input  logic              io0,
    input  logic [OPC_W-1:0]  byte_sh,
    input  logic [ADDR_W-1:0] addr_sh,
    output logic              byte_en,
    output lane_e             byte_lane,
    output logic              addr_en,
    output lane_e             addr_lane,
    output logic              rd_start,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_quad,
    output logic              cmd_valid,
    output logic [OPC_W-1:0]  cmd_opcode,
    output logic              cont_mode
);

    localparam int ADDR_CLKS_X2 = ADDR_W / 2;
    localparam int ADDR_CLKS_X4 = ADDR_W / 4;
    localparam int MODE_CLKS_X2 = OPC_W / 2;
    localparam int MODE_CLKS_X4 = OPC_W / 4;
    localparam int CNT_W        = $clog2(ADDR_CLKS_X2 + RESET_CLKS + 2);
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    state_e           state;
    lane_e            lane;
    logic [CNT_W-1:0] ph_cnt;
    logic [CNT_W-1:0] txn_cnt;
    logic             ones_ok;
    logic             cont_q;
    logic             cont_quad;
    logic [CNT_W-1:0] phase_len;
    logic             phase_last;
    logic             reset_hit;

    always_comb begin
        unique case (state)
            ST_OPCODE: phase_len = CNT_W'(OPC_W);
            ST_ADDR:   phase_len = (lane == LN_X4) ? CNT_W'(ADDR_CLKS_X4) : CNT_W'(ADDR_CLKS_X2);
            ST_MODE:   phase_len = (lane == LN_X4) ? CNT_W'(MODE_CLKS_X4) : CNT_W'(MODE_CLKS_X2);
            ST_DUMMY:  phase_len = CNT_W'(QUAD_DUMMY);
            default:   phase_len = CNT_W'(1);
        endcase
        phase_last = (ph_cnt == phase_len - 1'b1);
        reset_hit  = cont_q && ones_ok && (txn_cnt == CNT_W'(RESET_CLKS));
        byte_en    = rise && (state == ST_OPCODE || state == ST_MODE);
        byte_lane  = (state == ST_MODE) ? lane : LN_X1;
        addr_en    = rise && (state == ST_ADDR);
        addr_lane  = lane;
        cont_mode  = cont_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_OPCODE;
            lane       <= LN_X2;
            ph_cnt     <= '0;
            txn_cnt    <= '0;
            ones_ok    <= 1'b1;
            cont_q     <= 1'b0;
            cont_quad  <= 1'b0;
            rd_start   <= 1'b0;
            rd_addr    <= '0;
            rd_quad    <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_opcode <= '0;
        end else begin
            rd_start  <= 1'b0;
            cmd_valid <= 1'b0;
            if (cs_hi) begin
                ph_cnt  <= '0;
                txn_cnt <= '0;
                ones_ok <= 1'b1;
                if (reset_hit) begin
                    cont_q <= 1'b0;
                    state  <= ST_OPCODE;
                end else begin
                    state <= cont_q ? ST_ADDR : ST_OPCODE;
                    lane  <= cont_quad ? LN_X4 : LN_X2;
                end
            end else begin
                if (rise) begin
                    if (txn_cnt != CNT_SAT) txn_cnt <= txn_cnt + 1'b1;
                    if (txn_cnt < CNT_W'(RESET_CLKS) && !io0) ones_ok <= 1'b0;
                end
                unique case (state)
                    ST_OPCODE: if (rise) begin
                        ph_cnt <= phase_last ? '0 : ph_cnt + 1'b1;
                        if (phase_last) state <= ST_DECODE;
                    end
                    ST_DECODE: begin
                        if (byte_sh == OPC_DUAL_IO) begin
                            lane  <= LN_X2;
                            state <= ST_ADDR;
                        end else if (byte_sh == OPC_QUAD_IO) begin
                            lane  <= LN_X4;
                            state <= ST_ADDR;
                        end else begin
                            cmd_valid  <= 1'b1;
                            cmd_opcode <= byte_sh;
                            state      <= ST_HOLD;
                        end
                    end
                    ST_ADDR: if (rise) begin
                        ph_cnt <= phase_last ? '0 : ph_cnt + 1'b1;
                        if (phase_last) state <= ST_MODE;
                    end
                    ST_MODE: if (rise) begin
                        ph_cnt <= phase_last ? '0 : ph_cnt + 1'b1;
                        if (phase_last)
                            state <= (lane == LN_X4 && QUAD_DUMMY > 0) ? ST_DUMMY : ST_COMMIT;
                    end
                    ST_DUMMY: if (rise) begin
                        ph_cnt <= phase_last ? '0 : ph_cnt + 1'b1;
                        if (phase_last) state <= ST_COMMIT;
                    end
                    ST_COMMIT: begin
                        rd_start  <= 1'b1;
                        rd_addr   <= addr_sh;
                        rd_quad   <= (lane == LN_X4);
                        cont_q    <= is_cont_key(byte_sh);
                        cont_quad <= (lane == LN_X4);
                        state     <= ST_HOLD;
                    end
                    default: state <= ST_HOLD;
                endcase
            end
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_start |=> !rd_start); // R12

    AST_NO_CMD_IN_CONT: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !cont_q); // R7

    AST_FLAG_CHANGE_POINTS: assert property (@(posedge clk) disable iff (rst)
        !$stable(cont_q) |-> ($past(state) == ST_COMMIT || $past(cs_hi))); // R11

    AST_DISARM_SILENT: assert property (@(posedge clk) disable iff (rst)
        ($fell(cont_q) && $past(cs_hi)) |-> (!rd_start && !cmd_valid)); // R8

    AST_ADDR_WIDE_LANE: assert property (@(posedge clk) disable iff (rst)
        addr_en |-> (addr_lane != LN_X1)); // R3

endmodule

// File: rtl/cread_tracker.sv
module cread_tracker
    import cread_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int QUAD_DUMMY = QUAD_DUMMY_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [3:0]        io,
    output logic              rd_start,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_quad,
    output logic              cmd_valid,
    output logic [OPC_W-1:0]  cmd_opcode,
    output logic              cont_mode
);

    bus_evt_t          evt;
    logic              byte_en;
    lane_e             byte_lane;
    logic              addr_en;
    lane_e             addr_lane;
    logic [OPC_W-1:0]  byte_sh;
    logic [ADDR_W-1:0] addr_sh;

    cread_sampler u_sampler (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .io   (io),
        .evt  (evt)
    );

    cread_lane_shift #(.W(OPC_W)) u_byte_shift (
        .clk  (clk),
        .rst  (rst),
        .en   (byte_en),
        .lane (byte_lane),
        .io   (evt.io),
        .q    (byte_sh)
    );

    cread_lane_shift #(.W(ADDR_W)) u_addr_shift (
        .clk  (clk),
        .rst  (rst),
        .en   (addr_en),
        .lane (addr_lane),
        .io   (evt.io),
        .q    (addr_sh)
    );

    cread_sequencer #(.ADDR_W(ADDR_W), .QUAD_DUMMY(QUAD_DUMMY)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cs_hi      (evt.cs_hi),
        .rise       (evt.rise),
        .io0        (evt.io[0]),
        .byte_sh    (byte_sh),
        .addr_sh    (addr_sh),
        .byte_en    (byte_en),
        .byte_lane  (byte_lane),
        .addr_en    (addr_en),
        .addr_lane  (addr_lane),
        .rd_start   (rd_start),
        .rd_addr    (rd_addr),
        .rd_quad    (rd_quad),
        .cmd_valid  (cmd_valid),
        .cmd_opcode (cmd_opcode),
        .cont_mode  (cont_mode)
    );

endmodule

// File: tb/cread_tracker_tb.sv
`timescale 1ns/1ps
module cread_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [3:0]  io = 4'h0;
    logic        rd_start;
    logic [23:0] rd_addr;
    logic        rd_quad;
    logic        cmd_valid;
    logic [7:0]  cmd_opcode;
    logic        cont_mode;

    always #2.5 clk = ~clk;

    cread_tracker dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .io(io),
        .rd_start(rd_start), .rd_addr(rd_addr), .rd_quad(rd_quad),
        .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cont_mode(cont_mode)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // Output monitor
    int          n_start = 0;
    int          n_cmd   = 0;
    int          n_both  = 0;
    int          n_wide  = 0;
    logic [23:0] l_addr  = '0;
    logic        l_quad  = 1'b0;
    logic [7:0]  l_op    = '0;
    logic        prev_start = 1'b0;
    logic        prev_cmd   = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rd_start) begin n_start++; l_addr = rd_addr; l_quad = rd_quad; end
            if (cmd_valid) begin n_cmd++; l_op = cmd_opcode; end
            if (rd_start && cmd_valid) n_both++;
            if ((rd_start && prev_start) || (cmd_valid && prev_cmd)) n_wide++;
            prev_start = rd_start;
            prev_cmd   = cmd_valid;
        end
    end

    // Reference model of the continuous-read flag
    bit exp_cont = 1'b0;
    bit exp_quad = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [3:0] v);
        @(negedge clk);
        io = v;
        wait_clks(3);
        sclk = 1'b1;
        wait_clks(3);
        sclk = 1'b0;
    endtask

    task automatic cs_begin();
        @(negedge clk);
        cs_n = 1'b0;
        wait_clks(4);
    endtask

    task automatic cs_end();
        wait_clks(4);
        cs_n = 1'b1;
        wait_clks(6);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) pulse({3'b000, b[i]});
    endtask

    task automatic send_addr_mode(input bit quad, input logic [23:0] a, input logic [7:0] m);
        if (quad) begin
            for (int i = 0; i < 6; i++) pulse(a[23-4*i -: 4]);
            for (int i = 0; i < 2; i++) pulse(m[7-4*i -: 4]);
            for (int i = 0; i < 4; i++) pulse(4'h0);
        end else begin
            for (int i = 0; i < 12; i++) pulse({2'b00, a[23-2*i -: 2]});
            for (int i = 0; i < 4; i++) pulse({2'b00, m[7-2*i -: 2]});
        end
    endtask

    // Full read; opcode sent only when the model says continuous mode is off
    task automatic do_read(input string req, input bit quad, input logic [23:0] a, input logic [7:0] m);
        int s0 = n_start;
        int c0 = n_cmd;
        bit q  = exp_cont ? exp_quad : quad;
        cs_begin();
        if (!exp_cont) send_byte(q ? 8'hEB : 8'hBB);
        send_addr_mode(q, a, m);
        cs_end();
        check({req, " strobe count"}, n_start - s0, 1);
        check({req, " address"}, l_addr, a);
        check({req, " quad flag"}, l_quad, q);
        check({req, " no cmd"}, n_cmd - c0, 0);
        exp_cont = (m[7:4] == 4'hA);
        exp_quad = q;
        check({req, " R5 cont flag"}, cont_mode, exp_cont);
    endtask

    // Transaction of n clocks; IO0 taken from bits[i], upper lines scrambled
    task automatic bits_txn(input string req, input int n, input logic [15:0] bits);
        int s0 = n_start;
        int c0 = n_cmd;
        cs_begin();
        for (int i = 0; i < n; i++) pulse({3'(i * 5 + 3), bits[i]});
        cs_end();
        check({req, " no strobe"}, n_start - s0, 0);
        check({req, " no cmd"}, n_cmd - c0, 0);
        check({req, " cont flag"}, cont_mode, exp_cont);
    endtask

    // Transaction cut after 'cut' clocks following an optional opcode
    task automatic cut_txn(input string req, input bit with_op, input bit quad, input int cut);
        int s0 = n_start;
        int c0 = n_cmd;
        cs_begin();
        if (with_op) send_byte(quad ? 8'hEB : 8'hBB);
        for (int i = 0; i < cut; i++) pulse(i[0] ? 4'hA : 4'h5);
        cs_end();
        check({req, " R10 no strobe"}, n_start - s0, 0);
        check({req, " R10 no cmd"}, n_cmd - c0, 0);
        check({req, " R10 flag kept"}, cont_mode, exp_cont);
    endtask

    task automatic std_cmd(input string req, input logic [7:0] op);
        int s0 = n_start;
        int c0 = n_cmd;
        cs_begin();
        send_byte(op);
        cs_end();
        check({req, " cmd count"}, n_cmd - c0, 1);
        check({req, " opcode"}, l_op, op);
        check({req, " no strobe"}, n_start - s0, 0);
        check({req, " flag clear"}, cont_mode, 0);
    endtask

    initial begin
        wait_clks(6);
        rst = 1'b0;
        wait_clks(4);

        // R1: reset state
        check("R1 cont_mode", cont_mode, 0);
        check("R1 rd_start", rd_start, 0);
        check("R1 cmd_valid", cmd_valid, 0);

        // R2 / R1: every standard opcode decoded
        for (int op = 0; op < 256; op++) begin
            if (op != 8'hBB && op != 8'hEB) std_cmd("R2", 8'(op));
        end

        // R3 / R4 / R5 / R6 / R11: mode nibble sweep on both lane widths
        for (int q = 0; q < 2; q++) begin
            for (int nib = 0; nib < 16; nib++) begin
                logic [23:0] a = 24'h123456 ^ (24'(nib) * 24'h111111) ^ (24'(q) << 23);
                do_read(q ? "R4/R6" : "R3/R6", bit'(q), a, {4'(nib), ~4'(nib)});
            end
        end

        // R6: continuous mode armed by dual read, quad request still uses two lines
        do_read("R3 arm", 1'b0, 24'hABCDEF, 8'hA0);
        do_read("R6 dual keep", 1'b1, 24'h00F00F, 8'hA7);

        // R7 / R9: single-line opcodes ignored while armed
        bits_txn("R7 9Fh", 8, 16'h00F9);
        bits_txn("R7 0Bh", 8, 16'h00D0);

        // R9: near-miss disarm sequences
        bits_txn("R9 seven ones", 7, 16'h007F);
        bits_txn("R9 nine ones", 9, 16'h01FF);
        for (int k = 0; k < 8; k++) bits_txn("R9 zero bit", 8, 16'h00FF & ~(16'h1 << k));

        // R10: cuts while armed (dual)
        for (int c = 1; c < 16; c++) cut_txn("armed dual", 1'b0, 1'b0, c);

        // R8: disarm then standard decode restored
        exp_cont = 1'b0;
        bits_txn("R8 disarm dual", 8, 16'h00FF);
        std_cmd("R8 after disarm", 8'h9F);

        // Quad arm; contention of reset window with mode completion
        do_read("R4 arm", 1'b1, 24'h5A5A5A, 8'hA5);
        for (int c = 1; c < 12; c++) cut_txn("armed quad", 1'b0, 1'b1, c);
        do_read("R4 all ones read", 1'b1, 24'hFFFFFF, 8'hFF);
        check("R8 quad read not taken as disarm", cont_mode, 0);
        do_read("R4 rearm", 1'b1, 24'h000001, 8'hAF);
        exp_cont = 1'b0;
        bits_txn("R8 disarm quad", 8, 16'h00FF);
        std_cmd("R8 quad after disarm", 8'h0B);

        // R10: cuts with opcode, flag clear
        for (int c = 0; c < 16; c++) cut_txn("dual op", 1'b1, 1'b0, c);
        for (int c = 0; c < 12; c++) cut_txn("quad op", 1'b1, 1'b1, c);

        // R12: strobe shape over the whole run
        check("R12 overlap", n_both, 0);
        check("R12 width", n_wide, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule